// File: doc/BRIEF.md
# Partitioned LRU Flash Line Buffers

This block sits between a requester and a flash read port and keeps four recently fetched flash lines. Every request carries a line address and a flag saying whether it is an instruction fetch or a data access. When a held line matches, the block answers from its own storage. On a miss it fetches the line from flash, stores it in a buffer and answers with the fetched data.

A 2-bit mode input sets which buffers a miss may replace. In the shared modes any buffer may be used. In the two split modes the buffers are divided between instruction fetches and data accesses. A hit is served from any buffer, whatever the mode. Within the permitted group, an invalid buffer is filled first. If every buffer in the group is valid, the least-recently-used one is refilled.

A request may also ask for the next sequential line. After its response, the block fetches that line into the same group if it is not already held. The prefetched line keeps its old place in the recency order and is only made most-recently-used when a later request hits it.

Top module: `flash_line_buf`

## Requirements
- R1: Reset (active-low, asynchronous) leaves every buffer invalid, `req_ready_o` high and `rsp_valid_o` and `fetch_req_o` low. The first request after reset for any address misses.
- R2: When an accepted request matches a valid buffer, `rsp_valid_o` pulses for one cycle, in the cycle after acceptance, carrying that buffer's line. No flash fetch is made and the buffer becomes most-recently-used. A hit is served from any buffer, whatever the mode and access type.
- R3: An accepted request that misses makes exactly one fetch of its own line address. The response carries `fetch_data_i` in the cycle after `fetch_ack_i`, and the filled buffer becomes most-recently-used.
- R4: A miss fills the lowest-numbered invalid buffer in the permitted group. If the group has no invalid buffer, it fills the least-recently-used one. Recency is a strict ordering of all four buffers.
- R5: Mode 2'b00, and the reserved mode 2'b01, let any access replace any of the four buffers.
- R6: In mode 2'b10, instruction fetches (`req_instr_i`=1) may replace only buffers 0 and 1, and data accesses only buffers 2 and 3.
- R7: In mode 2'b11, instruction fetches may replace only buffers 0, 1 and 2, and data accesses only buffer 3.
- R8: A request with `req_next_i`=1 causes one fetch of line address+1 (wrapping) after its response, unless that line is already valid. The fetch goes into the victim of the request's own group and produces no response.
- R9: A prefetched line keeps the recency position of the buffer it replaced. It is promoted to most-recently-used only when a later request hits it.
- R10: `req_ready_o` is low while a line fill, or the prefetch decision, is in progress. A request for the line being prefetched is held off and then served from the buffer without a second fetch.
- R11: `fetch_req_o` stays high with a stable `fetch_addr_o` until `fetch_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 2 | Partition mode |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | ADDR_W | Requested line address |
| req_instr_i | input | 1 | 1 = instruction fetch, 0 = data access |
| req_next_i | input | 1 | Ask for a next-line prefetch after this request |
| rsp_valid_o | output | 1 | Response valid, one-cycle pulse |
| rsp_data_o | output | DATA_W | Response line data |
| fetch_req_o | output | 1 | Flash line fetch request |
| fetch_addr_o | output | ADDR_W | Flash line address |
| fetch_ack_i | input | 1 | Flash line delivered |
| fetch_data_i | input | DATA_W | Flash line data |

## Verification
The hardest case to reach is a victim choice that tells a correct recency order apart from a wrong one. Examples are a prefetched line that must still be the oldest buffer, or a split group whose oldest member differs from the oldest buffer overall. The stimulus table walks one long chain of hits and misses across all four modes, so each step starts from a known ordering. Each eviction is then proved by a later miss on the evicted address, and each survival by a later hit. Holding off a request for the line being prefetched needs a request raised in the same cycle as the preceding response, so a directed test drives it there.

// File: rtl/flb_pkg.sv
package flb_pkg;
  localparam int unsigned NUM_BUF = 4;
  localparam int unsigned IDX_W   = $clog2(NUM_BUF);

  localparam logic [1:0] CFG_POOL      = 2'b00;
  localparam logic [1:0] CFG_RSVD      = 2'b01;
  localparam logic [1:0] CFG_SPLIT_2_2 = 2'b10;
  localparam logic [1:0] CFG_SPLIT_3_1 = 2'b11;

  typedef logic [NUM_BUF-1:0] buf_vec_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_PCHK,
    ST_PFILL
  } fsm_e;
endpackage

// File: rtl/flb_group_mask.sv
module flb_group_mask
  import flb_pkg::*;
(
  input  logic [1:0] cfg_i,
  input  logic       instr_i,
  output buf_vec_t   mask_o
);
  always_comb begin
    case (cfg_i)
      CFG_SPLIT_2_2: mask_o = instr_i ? buf_vec_t'(4'b0011) : buf_vec_t'(4'b1100);
      CFG_SPLIT_3_1: mask_o = instr_i ? buf_vec_t'(4'b0111) : buf_vec_t'(4'b1000);
      default:       mask_o = '1;  // pool and reserved code
    endcase
  end
endmodule

// File: rtl/flb_victim_sel.sv
module flb_victim_sel #(
  parameter int unsigned NB = 4,
  parameter int unsigned IW = 2
) (
  input  logic [NB-1:0]         valid_i,
  input  logic [NB-1:0]         mask_i,
  input  logic [NB-1:0][IW-1:0] age_i,
  output logic [IW-1:0]         idx_o
);
  logic          inv_found;
  logic [IW-1:0] inv_idx;
  logic          old_found;
  logic [IW-1:0] old_idx;
  logic [IW-1:0] old_age;

  always_comb begin
    inv_found = 1'b0;
    inv_idx   = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (mask_i[i] && !valid_i[i]) begin
        inv_found = 1'b1;
        inv_idx   = IW'(i);
      end
    end
    old_found = 1'b0;
    old_idx   = '0;
    old_age   = '0;
    for (int i = 0; i < NB; i++) begin
      if (mask_i[i] && (!old_found || age_i[i] > old_age)) begin
        old_found = 1'b1;
        old_age   = age_i[i];
        old_idx   = IW'(i);
      end
    end
    idx_o = inv_found ? inv_idx : old_idx;
  end
endmodule

// File: rtl/flb_recency.sv
module flb_recency #(
  parameter int unsigned NB = 4,
  parameter int unsigned IW = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  promote_i,
  input  logic [IW-1:0]         promote_idx_i,
  output logic [NB-1:0][IW-1:0] age_o
);
  // age 0 = most recent, NB-1 = least recent; always a permutation
  logic [NB-1:0][IW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NB; i++) age_q[i] <= IW'(i);
    end else if (promote_i) begin
      for (int j = 0; j < NB; j++) begin
        if (IW'(j) == promote_idx_i) age_q[j] <= '0;
        else if (age_q[j] < age_q[promote_idx_i]) age_q[j] <= age_q[j] + 1'b1;
      end
    end
  end

  assign age_o = age_q;
endmodule

// File: rtl/flash_line_buf.sv
module flash_line_buf
  import flb_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_instr_i,
  input  logic              req_next_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_ack_i,
  input  logic [DATA_W-1:0] fetch_data_i
);
  fsm_e                           state_q;
  buf_vec_t                       valid_q;
  logic [NUM_BUF-1:0][ADDR_W-1:0] tag_q;
  logic [NUM_BUF-1:0][DATA_W-1:0] line_q;
  logic [IDX_W-1:0]               fill_idx_q;
  logic [ADDR_W-1:0]              fill_addr_q;
  logic [ADDR_W-1:0]              cur_addr_q;
  logic                           cur_instr_q;
  logic                           cur_next_q;

  logic [ADDR_W-1:0]              next_addr;
  buf_vec_t                       req_hit;
  buf_vec_t                       nxt_hit;
  logic [IDX_W-1:0]               hit_idx;
  logic                           sel_instr;
  buf_vec_t                       grp_mask;
  logic [IDX_W-1:0]               victim_idx;
  logic [NUM_BUF-1:0][IDX_W-1:0]  age;
  logic                           accept;
  logic                           acc_hit;
  logic                           acc_miss;
  logic                           fill_done;
  logic                           pf_alloc;
  logic                           alloc_en;
  logic [ADDR_W-1:0]              alloc_addr;
  buf_vec_t                       alloc_oh;
  logic                           promote_en;
  logic [IDX_W-1:0]               promote_idx;
  logic                           fill_is_pf;

  assign next_addr = cur_addr_q + ADDR_W'(1);

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_cmp
    assign req_hit[b] = valid_q[b] && (tag_q[b] == req_addr_i);
    assign nxt_hit[b] = valid_q[b] && (tag_q[b] == next_addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_BUF; i++) if (req_hit[i]) hit_idx = IDX_W'(i);
  end

  assign sel_instr = (state_q == ST_IDLE) ? req_instr_i : cur_instr_q;

  flb_group_mask u_mask (
    .cfg_i   (cfg_i),
    .instr_i (sel_instr),
    .mask_o  (grp_mask)
  );

  flb_victim_sel #(.NB(NUM_BUF), .IW(IDX_W)) u_victim (
    .valid_i (valid_q),
    .mask_i  (grp_mask),
    .age_i   (age),
    .idx_o   (victim_idx)
  );

  flb_recency #(.NB(NUM_BUF), .IW(IDX_W)) u_recency (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .promote_i     (promote_en),
    .promote_idx_i (promote_idx),
    .age_o         (age)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign fetch_req_o = (state_q == ST_FILL) || (state_q == ST_PFILL);
  assign fetch_addr_o = fill_addr_q;
  assign fill_is_pf  = (state_q == ST_PFILL);

  assign accept      = req_valid_i && req_ready_o;
  assign acc_hit     = accept && (|req_hit);
  assign acc_miss    = accept && !(|req_hit);
  assign fill_done   = fetch_req_o && fetch_ack_i;
  assign pf_alloc    = (state_q == ST_PCHK) && !(|nxt_hit);
  assign alloc_en    = acc_miss || pf_alloc;
  assign alloc_addr  = (state_q == ST_PCHK) ? next_addr : req_addr_i;
  assign alloc_oh    = alloc_en ? (buf_vec_t'(1) << victim_idx) : '0;
  // prefetch fills are not promoted
  assign promote_en  = acc_hit || ((state_q == ST_FILL) && fetch_ack_i);
  assign promote_idx = acc_hit ? hit_idx : fill_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      line_q  <= '0;
    end else begin
      if (alloc_en) begin
        valid_q[victim_idx] <= 1'b0;
        tag_q[victim_idx]   <= alloc_addr;
      end
      if (fill_done) begin
        valid_q[fill_idx_q] <= 1'b1;
        line_q[fill_idx_q]  <= fetch_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      fill_idx_q  <= '0;
      fill_addr_q <= '0;
      cur_addr_q  <= '0;
      cur_instr_q <= 1'b0;
      cur_next_q  <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cur_addr_q  <= req_addr_i;
            cur_instr_q <= req_instr_i;
            cur_next_q  <= req_next_i;
            if (|req_hit) begin
              rsp_valid_o <= 1'b1;
              rsp_data_o  <= line_q[hit_idx];
              if (req_next_i) state_q <= ST_PCHK;
            end else begin
              fill_idx_q  <= victim_idx;
              fill_addr_q <= req_addr_i;
              state_q     <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (fetch_ack_i) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= fetch_data_i;
            state_q     <= cur_next_q ? ST_PCHK : ST_IDLE;
          end
        end
        ST_PCHK: begin
          if (|nxt_hit) begin
            state_q <= ST_IDLE;
          end else begin
            fill_idx_q  <= victim_idx;
            fill_addr_q <= next_addr;
            state_q     <= ST_PFILL;
          end
        end
        default: begin
          if (fetch_ack_i) state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/flb_checker.sv
module flb_checker
  import flb_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_valid_i,
  input logic                          req_ready_o,
  input logic                          rsp_valid_o,
  input logic                          fetch_req_o,
  input logic                          fetch_ack_i,
  input logic [ADDR_W-1:0]             fetch_addr_o,
  input logic                          fill_is_pf,
  input logic                          alloc_en,
  input buf_vec_t                      alloc_oh,
  input buf_vec_t                      grp_mask,
  input logic [NUM_BUF-1:0][IDX_W-1:0] age
);
  p_fetch_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && !fetch_ack_i) |=> (fetch_req_o && $stable(fetch_addr_o)));

  p_no_accept_in_fill_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> !req_ready_o);

  p_accept_outcome_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (rsp_valid_o || fetch_req_o));

  p_ack_response_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && fetch_ack_i && !fill_is_pf) |=> rsp_valid_o);

  p_prefetch_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && fetch_ack_i && fill_is_pf) |=> !rsp_valid_o);

  p_victim_in_group_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en |-> ($countones(alloc_oh) == 1 && (alloc_oh & ~grp_mask) == '0));

  for (genvar r = 0; r < NUM_BUF; r++) begin : g_rank
    buf_vec_t rank_hit;
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_b
      assign rank_hit[b] = (age[b] == IDX_W'(r));
    end
    p_rank_unique_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(rank_hit) == 1);
  end
endmodule

bind flash_line_buf flb_checker #(.ADDR_W(ADDR_W)) u_flb_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .fetch_req_o  (fetch_req_o),
  .fetch_ack_i  (fetch_ack_i),
  .fetch_addr_o (fetch_addr_o),
  .fill_is_pf   (fill_is_pf),
  .alloc_en     (alloc_en),
  .alloc_oh     (alloc_oh),
  .grp_mask     (grp_mask),
  .age          (age)
);

// File: tb/flash_line_buf_tb_top.sv
`timescale 1ns/1ps
module flash_line_buf_tb_top;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int FL_LAT = 2;
  localparam int NVEC = 32;

  typedef struct packed {
    logic [1:0]    cfg;
    logic          instr;
    logic [AW-1:0] addr;
    logic          nxt;
    logic          dem;
    logic          pf;
  } vec_t;

  // chained sequence: each step relies on the recency order left by the previous ones
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 1'b1, 12'h010, 1'b0, 1'b1, 1'b0},
    '{2'b00, 1'b0, 12'h020, 1'b0, 1'b1, 1'b0},
    '{2'b00, 1'b1, 12'h030, 1'b0, 1'b1, 1'b0},
    '{2'b00, 1'b0, 12'h040, 1'b0, 1'b1, 1'b0},
    '{2'b00, 1'b1, 12'h010, 1'b0, 1'b0, 1'b0},
    '{2'b00, 1'b0, 12'h050, 1'b0, 1'b1, 1'b0},
    '{2'b00, 1'b0, 12'h020, 1'b0, 1'b1, 1'b0},
    '{2'b00, 1'b1, 12'h010, 1'b0, 1'b0, 1'b0},
    '{2'b10, 1'b1, 12'h060, 1'b0, 1'b1, 1'b0},
    '{2'b10, 1'b1, 12'h070, 1'b0, 1'b1, 1'b0},
    '{2'b10, 1'b0, 12'h010, 1'b0, 1'b1, 1'b0},
    '{2'b10, 1'b1, 12'h020, 1'b0, 1'b0, 1'b0},
    '{2'b10, 1'b0, 12'h080, 1'b0, 1'b1, 1'b0},
    '{2'b10, 1'b1, 12'h060, 1'b0, 1'b0, 1'b0},
    '{2'b11, 1'b0, 12'h090, 1'b0, 1'b1, 1'b0},
    '{2'b11, 1'b0, 12'h0A0, 1'b0, 1'b1, 1'b0},
    '{2'b11, 1'b0, 12'h090, 1'b0, 1'b1, 1'b0},
    '{2'b11, 1'b1, 12'h0B0, 1'b0, 1'b1, 1'b0},
    '{2'b11, 1'b1, 12'h0C0, 1'b0, 1'b1, 1'b0},
    '{2'b11, 1'b1, 12'h060, 1'b0, 1'b0, 1'b0},
    '{2'b01, 1'b1, 12'h0D0, 1'b0, 1'b1, 1'b0},
    '{2'b01, 1'b0, 12'h090, 1'b0, 1'b1, 1'b0},
    '{2'b00, 1'b1, 12'h100, 1'b1, 1'b1, 1'b1},
    '{2'b00, 1'b0, 12'h200, 1'b0, 1'b1, 1'b0},
    '{2'b00, 1'b1, 12'h101, 1'b0, 1'b1, 1'b0},
    '{2'b00, 1'b1, 12'h300, 1'b1, 1'b1, 1'b1},
    '{2'b00, 1'b1, 12'h301, 1'b0, 1'b0, 1'b0},
    '{2'b00, 1'b0, 12'h400, 1'b0, 1'b1, 1'b0},
    '{2'b00, 1'b1, 12'h301, 1'b0, 1'b0, 1'b0},
    '{2'b00, 1'b1, 12'h300, 1'b0, 1'b0, 1'b0},
    '{2'b00, 1'b1, 12'h300, 1'b1, 1'b0, 1'b0},
    '{2'b00, 1'b1, 12'h301, 1'b1, 1'b0, 1'b1}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [1:0]    cfg_i;
  logic          req_valid_i;
  logic          req_ready_o;
  logic [AW-1:0] req_addr_i;
  logic          req_instr_i;
  logic          req_next_i;
  logic          rsp_valid_o;
  logic [DW-1:0] rsp_data_o;
  logic          fetch_req_o;
  logic [AW-1:0] fetch_addr_o;
  logic          fetch_ack_i;
  logic [DW-1:0] fetch_data_i;

  int n_chk = 0;
  int n_fail = 0;
  int n_fetch = 0;

  always #10 clk_i = ~clk_i;

  flash_line_buf #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg_i),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_addr_i   (req_addr_i),
    .req_instr_i  (req_instr_i),
    .req_next_i   (req_next_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_data_o   (rsp_data_o),
    .fetch_req_o  (fetch_req_o),
    .fetch_addr_o (fetch_addr_o),
    .fetch_ack_i  (fetch_ack_i),
    .fetch_data_i (fetch_data_i)
  );

  function automatic logic [DW-1:0] line_data(input logic [AW-1:0] a);
    return {8'hA5, ~a, a};
  endfunction

  function automatic string dem_tag(input int i);
    if (i < 8) return "R4";
    if (i < 14) return "R6";
    if (i < 20) return "R7";
    if (i < 22) return "R5";
    return "R9";
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash model: acknowledges after FL_LAT idle cycles
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    fetch_ack_i = 1'b0;
    fetch_data_i = '0;
    forever begin
      @(negedge clk_i);
      if (fetch_ack_i) fetch_ack_i = 1'b0;
      else if (fetch_req_o) begin
        if (wait_cnt == FL_LAT) begin
          fetch_ack_i = 1'b1;
          fetch_data_i = line_data(fetch_addr_o);
          n_fetch++;
          wait_cnt = 0;
        end else wait_cnt++;
      end
    end
  end

  // called at a negedge, returns at the negedge where the response is visible
  task automatic do_req(input logic instr, input logic [AW-1:0] addr, input logic nxt,
                        output logic [DW-1:0] data, output int dem, output int lat);
    int n0;
    n0 = n_fetch;
    req_valid_i = 1'b1;
    req_instr_i = instr;
    req_addr_i  = addr;
    req_next_i  = nxt;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    req_next_i  = 1'b0;
    lat = 0;
    while (!rsp_valid_o) begin
      @(negedge clk_i);
      lat++;
    end
    data = rsp_data_o;
    dem  = n_fetch - n0;
  endtask

  task automatic wait_idle();
    while (!req_ready_o) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    int dem, lat, n1, n_start;
    rst_ni = 1'b0;
    cfg_i = 2'b00;
    req_valid_i = 1'b0;
    req_addr_i = '0;
    req_instr_i = 1'b0;
    req_next_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 ready", 32'(req_ready_o), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid_o), 32'd0);
    chk("R1 fetch_req", 32'(fetch_req_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      cfg_i = VECS[i].cfg;
      do_req(VECS[i].instr, VECS[i].addr, VECS[i].nxt, d, dem, lat);
      n1 = n_fetch;
      chk(VECS[i].dem ? "R3 data" : "R2 data", d, line_data(VECS[i].addr));
      chk(i == 0 ? "R1 first miss" : dem_tag(i), 32'(dem), 32'(VECS[i].dem));
      if (!VECS[i].dem) chk("R2 latency", 32'(lat), 32'd0);
      wait_idle();
      chk("R8 prefetch count", 32'(n_fetch - n1), 32'(VECS[i].pf));
    end

    // R10: request for the line being prefetched, raised in the response cycle
    n_start = n_fetch;
    do_req(1'b1, 12'h500, 1'b1, d, dem, lat);
    chk("R10 ready low after response", 32'(req_ready_o), 32'd0);
    do_req(1'b1, 12'h501, 1'b0, d, dem, lat);
    chk("R10 data", d, line_data(12'h501));
    chk("R10 no duplicate fetch", 32'(n_fetch - n_start), 32'd2);

    // R8: next line wraps to address 0
    do_req(1'b1, 12'hFFF, 1'b1, d, dem, lat);
    wait_idle();
    do_req(1'b1, 12'h000, 1'b0, d, dem, lat);
    chk("R8 wrap hit", 32'(dem), 32'd0);
    chk("R8 wrap data", d, line_data(12'h000));

    // R7: one data buffer, so the prefetch replaces the line just fetched
    cfg_i = 2'b11;
    do_req(1'b0, 12'h600, 1'b1, d, dem, lat);
    n1 = n_fetch;
    wait_idle();
    chk("R8 split prefetch", 32'(n_fetch - n1), 32'd1);
    do_req(1'b0, 12'h601, 1'b0, d, dem, lat);
    chk("R7 prefetched hit", 32'(dem), 32'd0);
    do_req(1'b0, 12'h600, 1'b0, d, dem, lat);
    chk("R7 single data buffer", 32'(dem), 32'd1);

    // R1: reset in mid-run invalidates buffers
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 ready in reset", 32'(req_ready_o), 32'd1);
    chk("R1 rsp in reset", 32'(rsp_valid_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_req(1'b0, 12'h600, 1'b0, d, dem, lat);
    chk("R1 miss after reset", 32'(dem), 32'd1);
    chk("R3 data after reset", d, line_data(12'h600));

    finish_run();
  end
endmodule